// File: doc/BRIEF.md
# Guard-Round-Sticky Mantissa Rounder

This block is the rounding stage of a floating-point datapath. It takes an unsigned mantissa whose two lowest bits carry the guard and round positions, a separate sticky bit, the operand sign and a two-bit rounding-mode field. It drops the guard and round bits, decides from the mode whether to add one unit in the last place, and reports whether the value was inexact and whether it was rounded up.

The result is registered once. A new operand is accepted on any cycle where `in_valid` is high, and the result appears one cycle later. A carry produced by the increment runs through the whole mantissa. If that carry reaches the leading bit, the result is a mantissa of 2.0. This stage does not correct that case; the next stage finds it through `out_round_up` and renormalises. Exponent handling and trapping belong to other stages.

Top module: `grs_rounder`

## Requirements
- R1: During and directly after a synchronous active-low reset, `out_valid`, `out_mant`, `out_round_up`, `out_inexact` and `out_frac_inexact` are all zero.
- R2: `out_valid` equals `in_valid` delayed by one cycle. While `in_valid` is low, the data and flag outputs keep their previous values, regardless of how the other inputs change.
- R3: One cycle after an accepted operand, `out_mant` equals `in_mant` shifted right by two, plus one when `out_round_up` is 1. The result is taken modulo 2^(IN_W-2).
- R4: If `in_mant[1]` (guard), `in_mant[0]` (round) and `in_sticky` are all 0, there is no increment, and both inexact flags are 0.
- R5: If any of guard, round or sticky is 1, `out_inexact` and `out_frac_inexact` are both 1.
- R6: Mode 2'b00 rounds to nearest, ties to even. It increments only when guard is 1 and at least one of round, sticky or the shifted mantissa's LSB is 1.
- R7: Mode 2'b01 rounds toward zero and never increments.
- R8: Mode 2'b10 rounds toward plus infinity. It increments only when the operand is inexact and `in_sign` is 0.
- R9: Mode 2'b11 rounds toward minus infinity. It increments only when the operand is inexact and `in_sign` is 1.
- R10: `out_round_up` is 1 exactly when the increment was applied. The increment's carry runs through every bit of the shifted mantissa, for example 0x00FFFFFF becomes 0x01000000.
- R11: A shifted mantissa of all ones that is incremented wraps to zero, with `out_round_up` set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_mant | input | IN_W | Mantissa; bit 1 is guard, bit 0 is round |
| in_sticky | input | 1 | OR of all bits below round |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_mode | input | 2 | 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result present |
| out_mant | output | IN_W-2 | Shifted and possibly incremented mantissa |
| out_round_up | output | 1 | An increment was applied |
| out_inexact | output | 1 | Discarded bits were non-zero |
| out_frac_inexact | output | 1 | Fraction inexact status, set together with `out_inexact` |

## Verification
Every result comes from a single register stage, so a fault in the mode decode or the increment decision shows at the ports in the cycle right after the operand. It appears as `out_round_up` disagreeing with the mode and sign, and as `out_mant` off by one from the shifted input. A broken carry chain shows only when the low result bits are all ones, so the bench drives both carry-into-top and full-wrap mantissas. A wrong capture enable shows as outputs that change while `in_valid` is low.

// File: rtl/rnd_pkg.sv
// Package: shared encodings for the mantissa rounding stage.
// Assumes a two-bit mode field; every code value is defined.
package rnd_pkg;
    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_POS_INF = 2'b10,
        RM_NEG_INF = 2'b11
    } rmode_e;
endpackage

// File: rtl/grs_decide.sv
// Module: grs_decide
// Decides, from guard/round/sticky, the shifted LSB, sign and mode, whether
// to add one ulp, and whether the value is inexact. Purely combinational.
module grs_decide (
    input  logic            guard_bit,
    input  logic            round_bit,
    input  logic            sticky_bit,
    input  logic            kept_lsb,
    input  logic            sign_bit,
    input  rnd_pkg::rmode_e mode,
    output logic            do_inc,
    output logic            inexact
);
    // Purpose: any discarded weight means the result is not exact.
    always_comb inexact = guard_bit | round_bit | sticky_bit;

    // Purpose: per-mode increment choice; ties go to the even neighbour.
    always_comb begin
        do_inc = 1'b0;
        unique case (mode)
            rnd_pkg::RM_NEAREST: do_inc = guard_bit & (round_bit | sticky_bit | kept_lsb);
            rnd_pkg::RM_ZERO:    do_inc = 1'b0;
            rnd_pkg::RM_POS_INF: do_inc = inexact & ~sign_bit;
            rnd_pkg::RM_NEG_INF: do_inc = inexact & sign_bit;
            default:             do_inc = guard_bit & (round_bit | sticky_bit | kept_lsb);
        endcase
    end
endmodule

// File: rtl/mant_incr.sv
// Module: mant_incr
// Adds a single carry-in to a W-bit mantissa with a full-width carry chain.
// The carry out of the top bit is dropped; the result wraps modulo 2^W.
module mant_incr #(
    parameter int W = 32
) (
    input  logic [W-1:0] base,
    input  logic         cin,
    output logic [W-1:0] sum
);
    logic [W-1:0] carry;

    assign carry[0] = cin;

    // Purpose: one half-adder cell per bit, chained from LSB to MSB.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = base[i] ^ carry[i];
        if (i < W - 1) begin : g_chain
            assign carry[i+1] = base[i] & carry[i];
        end
    end
endmodule

// File: rtl/grs_rounder.sv
// Module: grs_rounder (top)
// Rounding stage: drops guard/round, applies the mode's increment and
// registers the result and status flags for one cycle of latency.
// Assumes IN_W >= 3. A mantissa that carries to 2.0 is left for the consumer.
module grs_rounder #(
    parameter int IN_W = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_mant,
    input  logic              in_sticky,
    input  logic              in_sign,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [IN_W-3:0]   out_mant,
    output logic              out_round_up,
    output logic              out_inexact,
    output logic              out_frac_inexact
);
    localparam int OUT_W = IN_W - 2;

    logic [OUT_W-1:0] kept;
    logic [OUT_W-1:0] rounded;
    logic             inc;
    logic             inx;

    // Purpose: strip the guard and round positions before any increment.
    always_comb kept = in_mant[IN_W-1:2];

    grs_decide u_decide (
        .guard_bit  (in_mant[1]),
        .round_bit  (in_mant[0]),
        .sticky_bit (in_sticky),
        .kept_lsb   (kept[0]),
        .sign_bit   (in_sign),
        .mode       (rnd_pkg::rmode_e'(in_mode)),
        .do_inc     (inc),
        .inexact    (inx)
    );

    mant_incr #(.W(OUT_W)) u_incr (
        .base (kept),
        .cin  (inc),
        .sum  (rounded)
    );

    // Purpose: output register; captures only accepted operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid        <= 1'b0;
            out_mant         <= '0;
            out_round_up     <= 1'b0;
            out_inexact      <= 1'b0;
            out_frac_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mant         <= rounded;
                out_round_up     <= inc;
                out_inexact      <= inx;
                out_frac_inexact <= inx;
            end
        end
    end
endmodule

// File: rtl/grs_rounder_chk.sv
// Module: grs_rounder_chk
// Checker bound to grs_rounder; relates accepted inputs to the next-cycle outputs.
module grs_rounder_chk #(
    parameter int IN_W = 34
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [IN_W-1:0] in_mant,
    input logic            in_sticky,
    input logic            in_sign,
    input logic [1:0]      in_mode,
    input logic            out_valid,
    input logic [IN_W-3:0] out_mant,
    input logic            out_round_up,
    input logic            out_inexact,
    input logic            out_frac_inexact
);
    localparam int OUT_W = IN_W - 2;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_mant) && $stable(out_round_up) && $stable(out_inexact)));
    assert_shift_plus_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_mant == OUT_W'($past(in_mant[IN_W-1:2]) + OUT_W'(out_round_up))));
    assert_exact_no_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mant[1:0] == 2'b00 && !in_sticky) |=> (!out_inexact && !out_round_up));
    assert_inexact_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_mant[1:0] != 2'b00 || in_sticky)) |=> (out_inexact && out_frac_inexact));
    assert_nearest_below_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b00 && !in_mant[1]) |=> !out_round_up);
    assert_zero_never_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b01) |=> !out_round_up);
    assert_pos_negative_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b10 && in_sign) |=> !out_round_up);
    assert_neg_positive_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b11 && !in_sign) |=> !out_round_up);
endmodule

bind grs_rounder grs_rounder_chk #(.IN_W(IN_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .in_valid         (in_valid),
    .in_mant          (in_mant),
    .in_sticky        (in_sticky),
    .in_sign          (in_sign),
    .in_mode          (in_mode),
    .out_valid        (out_valid),
    .out_mant         (out_mant),
    .out_round_up     (out_round_up),
    .out_inexact      (out_inexact),
    .out_frac_inexact (out_frac_inexact)
);

// File: tb/sim_grs_rounder.sv
// Bench: directed scenarios for grs_rounder, one task each, plus a mode sweep.
module sim_grs_rounder;
    localparam int IN_W  = 34;
    localparam int OUT_W = IN_W - 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [IN_W-1:0]   in_mant = '0;
    logic              in_sticky = 1'b0;
    logic              in_sign = 1'b0;
    logic [1:0]        in_mode = 2'b00;
    logic              out_valid;
    logic [OUT_W-1:0]  out_mant;
    logic              out_round_up;
    logic              out_inexact;
    logic              out_frac_inexact;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5ns clk = ~clk;

    grs_rounder #(.IN_W(IN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
        .in_sticky(in_sticky), .in_sign(in_sign), .in_mode(in_mode),
        .out_valid(out_valid), .out_mant(out_mant), .out_round_up(out_round_up),
        .out_inexact(out_inexact), .out_frac_inexact(out_frac_inexact)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Independent model of the requirements (R3..R11).
    task automatic model(input logic [OUT_W-1:0] base, input logic [2:0] grs,
                         input logic sign, input logic [1:0] mode,
                         output logic [OUT_W-1:0] e_mant, output logic e_up, output logic e_inx);
        logic g, r, s;
        {g, r, s} = grs;
        e_inx = g | r | s;
        case (mode)
            2'b00:   e_up = g & (r | s | base[0]);
            2'b01:   e_up = 1'b0;
            2'b10:   e_up = e_inx & !sign;
            default: e_up = e_inx & sign;
        endcase
        e_mant = base + OUT_W'(e_up);
    endtask

    // Drive one operand for one cycle; results are registered at the edge in between.
    task automatic apply(input logic [OUT_W-1:0] base, input logic [2:0] grs,
                         input logic sign, input logic [1:0] mode);
        @(negedge clk);
        in_valid  = 1'b1;
        in_mant   = {base, grs[2:1]};
        in_sticky = grs[0];
        in_sign   = sign;
        in_mode   = mode;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic run(input string req, input logic [OUT_W-1:0] base, input logic [2:0] grs,
                       input logic sign, input logic [1:0] mode,
                       input logic [OUT_W-1:0] e_mant, input logic e_up, input logic e_inx);
        apply(base, grs, sign, mode);
        chk({req, " valid"}, 64'(out_valid), 64'd1);
        chk({req, " mant"}, 64'(out_mant), 64'(e_mant));
        chk({req, " round_up"}, 64'(out_round_up), 64'(e_up));
        chk({req, " inexact"}, 64'(out_inexact), 64'(e_inx));
        chk({req, " frac_inexact"}, 64'(out_frac_inexact), 64'(e_inx));
    endtask

    task automatic t_reset_R1();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid", 64'(out_valid), 64'd0);
        chk("R1 mant", 64'(out_mant), 64'd0);
        chk("R1 flags", 64'({out_round_up, out_inexact, out_frac_inexact}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 64'({out_valid, out_mant}), 64'd0);
    endtask

    task automatic t_exact_R4();
        run("R4 exact pos", 32'h1234_5678, 3'b000, 1'b0, 2'b10, 32'h1234_5678, 1'b0, 1'b0);
        run("R4 exact near", 32'h0000_0011, 3'b000, 1'b1, 2'b00, 32'h0000_0011, 1'b0, 1'b0);
    endtask

    task automatic t_nearest_R6();
        run("R6 tie even", 32'h10, 3'b100, 1'b0, 2'b00, 32'h10, 1'b0, 1'b1);
        run("R6 tie odd", 32'h11, 3'b100, 1'b0, 2'b00, 32'h12, 1'b1, 1'b1);
        run("R6 above half", 32'h10, 3'b110, 1'b1, 2'b00, 32'h11, 1'b1, 1'b1);
        run("R6 sticky half", 32'h10, 3'b101, 1'b0, 2'b00, 32'h11, 1'b1, 1'b1);
        run("R6 below half R5", 32'h10, 3'b011, 1'b0, 2'b00, 32'h10, 1'b0, 1'b1);
    endtask

    task automatic t_zero_R7();
        run("R7 trunc pos", 32'h10, 3'b111, 1'b0, 2'b01, 32'h10, 1'b0, 1'b1);
        run("R7 trunc neg", 32'h11, 3'b110, 1'b1, 2'b01, 32'h11, 1'b0, 1'b1);
    endtask

    task automatic t_directed_R8_R9();
        run("R8 pos up", 32'h10, 3'b010, 1'b0, 2'b10, 32'h11, 1'b1, 1'b1);
        run("R8 neg down", 32'h10, 3'b010, 1'b1, 2'b10, 32'h10, 1'b0, 1'b1);
        run("R9 neg up", 32'h10, 3'b001, 1'b1, 2'b11, 32'h11, 1'b1, 1'b1);
        run("R9 pos down", 32'h10, 3'b001, 1'b0, 2'b11, 32'h10, 1'b0, 1'b1);
    endtask

    task automatic t_carry_R10_R11();
        run("R10 carry", 32'h00FF_FFFF, 3'b001, 1'b0, 2'b10, 32'h0100_0000, 1'b1, 1'b1);
        run("R10 tie carry", 32'h7FFF_FFFF, 3'b100, 1'b0, 2'b00, 32'h8000_0000, 1'b1, 1'b1);
        run("R11 wrap", 32'hFFFF_FFFF, 3'b110, 1'b1, 2'b11, 32'h0000_0000, 1'b1, 1'b1);
    endtask

    task automatic t_hold_R2();
        logic [OUT_W-1:0] m0;
        apply(32'h0000_00AB, 3'b111, 1'b0, 2'b10);
        m0 = out_mant;
        chk("R2 captured", 64'(m0), 64'h0000_00AC);
        @(negedge clk);
        in_mant = '1; in_sticky = 1'b1; in_sign = 1'b1; in_mode = 2'b11;
        repeat (3) begin
            @(negedge clk);
            chk("R2 idle valid", 64'(out_valid), 64'd0);
            chk("R2 idle hold", 64'({out_mant, out_round_up, out_inexact}), 64'({m0, 1'b1, 1'b1}));
        end
    endtask

    task automatic t_sweep_R3();
        logic [OUT_W-1:0] bases [5];
        logic [OUT_W-1:0] em;
        logic eu, ei;
        bases[0] = 32'h0000_0000; bases[1] = 32'hA5A5_A5A4; bases[2] = 32'hA5A5_A5A5;
        bases[3] = 32'h00FF_FFFF; bases[4] = 32'hFFFF_FFFF;
        for (int b = 0; b < 5; b++)
            for (int md = 0; md < 4; md++)
                for (int sg = 0; sg < 2; sg++)
                    for (int gr = 0; gr < 8; gr++) begin
                        model(bases[b], 3'(gr), 1'(sg), 2'(md), em, eu, ei);
                        run("R3 sweep", bases[b], 3'(gr), 1'(sg), 2'(md), em, eu, ei);
                    end
    endtask

    initial begin
        t_reset_R1();
        t_exact_R4();
        t_nearest_R6();
        t_zero_R7();
        t_directed_R8_R9();
        t_carry_R10_R11();
        t_hold_R2();
        t_sweep_R3();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule